// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects event pulses from up to a parameterized number of interrupt sources (twelve by default) for a small 8-bit processor core. Each source holds its own pending latch. A pending source requests service only when its enable bit is set. The enable bits are written through 8-bit enable registers. A single global enable, which the core controls with disable, enable and return-from-interrupt strobes, then gates the combined request before it reaches the core.

At each instruction boundary the core raises a strobe. If a request is being presented at that moment, the interrupt is taken. The controller clears the global enable and clears the pending latch of the winning source, which is the lowest-numbered pending-and-enabled source. One cycle later it presents a vector address with a one-cycle valid pulse, and the core uses that address for its automatic call. A sense bit reports pending-and-enabled work even while the global enable is off, so polling firmware can still see it. A status byte exposes both the sense bit and the global enable.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the global enable, all enable bits and all pending latches are zero, so `irq`, `sense`, `vec_valid` and `status` are all 0.
- R2: A high `src_evt[n]` at a clock edge sets pending latch n. The latch stays set across any number of cycles until source n is serviced or reset is applied.
- R3: Asserting `en_wr[r]` loads `en_wdata[b]` into the enable of source r*8+b. A pending source contributes to `sense` only while its enable is 1, and a latch that was set while disabled still requests once it is enabled.
- R4: When several sources are pending and enabled, the lowest-numbered one is serviced first.
- R5: An interrupt is taken only at an edge where `insn_done` and `irq` are both high. `vec_valid` is high for exactly the one cycle after that edge and low at all other times.
- R6: Taking an interrupt clears the global enable and the winner's pending latch. It presents `vec_addr` = 2*(n+1) for winner n, so source 0 maps to 0x0002 and source 11 maps to 0x0018.
- R7: `di_stb` clears the global enable, and `ei_stb` or `reti_stb` sets it. A take clears it even if EI or RETI arrives at the same edge, and DI wins over EI or RETI.
- R8: `sense` is 1 whenever any source is both pending and enabled, whatever the global enable. `status` bit 7 is `sense`, bit 2 is the global enable, and the other bits are 0.
- R9: `irq` equals `sense` AND the global enable, so it drops in the cycle after a take or a DI.
- R10: If an event for source n arrives at the same edge that a take clears latch n, the latch stays set.
- R11: An EI inside a handler lets the next pending-and-enabled source be taken at the following instruction boundary, which nests interrupts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | One-cycle event pulse per source |
| en_wr | input | NUM_REGS | Write strobe per enable register |
| en_wdata | input | REG_W | Enable register write data |
| di_stb | input | 1 | Disable global enable |
| ei_stb | input | 1 | Enable global enable |
| reti_stb | input | 1 | Return from handler, sets global enable |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| irq | output | 1 | Interrupt request to the core |
| vec_valid | output | 1 | One-cycle pulse: vector address is valid |
| vec_addr | output | ADDR_W | Vector address of the serviced source |
| sense | output | 1 | Some source is pending and enabled |
| status | output | 8 | Bit 7 sense, bit 2 global enable |

## Verification
`sense`, `irq` and `status` are decoded directly from registered state. A stimulus applied before an edge therefore shows on them right after that edge, and `vec_valid` and `vec_addr` appear in that same post-edge cycle as a pulse. The bench drives its inputs one nanosecond after a rising edge. It computes the reference state for the next edge in advance and compares every output one nanosecond after that edge. Directed scenes for priority, enable gating, nesting and event-at-clear then check the vector seen in the cycle after each take.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   // Global-enable update selected at each edge
   typedef enum logic [1:0] {
      GIE_HOLD  = 2'd0,
      GIE_CLEAR = 2'd1,
      GIE_SET   = 2'd2
   } gie_op_e;

   localparam int STAT_W         = 8;
   localparam int STAT_SENSE_BIT = 7;
   localparam int STAT_GIE_BIT   = 2;

   function automatic int regs_for(input int n_src, input int reg_w);
      return (n_src + reg_w - 1) / reg_w;
   endfunction

   function automatic int idx_w_for(input int n_src);
      return (n_src > 1) ? $clog2(n_src) : 1;
   endfunction
endpackage

// File: rtl/pvic_enable_bank.sv
module pvic_enable_bank #(
   parameter int NUM_SRC  = 12,
   parameter int REG_W    = 8,
   parameter int NUM_REGS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] wr,
   input  logic [REG_W-1:0]    wdata,
   output logic [NUM_SRC-1:0]  en
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         localparam int RIDX = i / REG_W;
         localparam int BIDX = i % REG_W;
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (wr[RIDX]) bit_q <= wdata[BIDX];
         end
         assign en[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/pvic_pending.sv
module pvic_pending #(
   parameter int NUM_SRC = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] pend
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_latch
         logic q;
         // a new event outranks a clear in the same cycle
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= evt[i] | (q & ~clr[i]);
         end
         assign pend[i] = q;
      end
   endgenerate
endmodule

// File: rtl/pvic_prio_enc.sv
module pvic_prio_enc #(
   parameter int NUM_SRC  = 12,
   parameter int IDX_W    = 4,
   parameter bit LOW_WINS = 1'b1
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   assign any = |req;

   generate
      if (LOW_WINS) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pvic_vec_gen.sv
module pvic_vec_gen #(
   parameter int IDX_W      = 4,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 2,
   parameter int VEC_STRIDE = 2
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam bit POW2 = (VEC_STRIDE > 0) && ((VEC_STRIDE & (VEC_STRIDE - 1)) == 0);
   localparam int SHIFT = (VEC_STRIDE > 1) ? $clog2(VEC_STRIDE) : 0;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

   generate
      if (POW2) begin : g_shift
         assign addr = BASE + (ADDR_W'(idx) << SHIFT);
      end else begin : g_mult
         assign addr = BASE + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);
      end
   endgenerate
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import pvic_pkg::*;
#(
   parameter int NUM_SRC    = 12,
   parameter int REG_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 2,
   parameter int VEC_STRIDE = 2,
   parameter bit LOW_WINS   = 1'b1,
   localparam int NUM_REGS  = regs_for(NUM_SRC, REG_W),
   localparam int IDX_W     = idx_w_for(NUM_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_evt,
   input  logic [NUM_REGS-1:0] en_wr,
   input  logic [REG_W-1:0]    en_wdata,
   input  logic                di_stb,
   input  logic                ei_stb,
   input  logic                reti_stb,
   input  logic                insn_done,
   output logic                irq,
   output logic                vec_valid,
   output logic [ADDR_W-1:0]   vec_addr,
   output logic                sense,
   output logic [STAT_W-1:0]   status
);
   // elaboration-time parameter checks
   generate
      if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_src
         $error("prio_vec_intc: NUM_SRC out of range");
      end
      if (REG_W < 1 || REG_W > 32) begin : g_bad_regw
         $error("prio_vec_intc: REG_W out of range");
      end
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addrw
         $error("prio_vec_intc: ADDR_W out of range");
      end
      if (VEC_STRIDE < 1) begin : g_bad_stride
         $error("prio_vec_intc: VEC_STRIDE must be positive");
      end
      if (ADDR_W <= 30 && VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE >= (1 << ADDR_W)) begin : g_bad_fit
         $error("prio_vec_intc: vector table does not fit ADDR_W");
      end
   endgenerate

   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] req;
   logic [NUM_SRC-1:0] clr;
   logic               any_req;
   logic [IDX_W-1:0]   win_idx;
   logic [ADDR_W-1:0]  win_addr;
   logic               gie_q;
   logic               take;
   gie_op_e            gie_op;
   logic               vv_q;
   logic [ADDR_W-1:0]  va_q;

   pvic_enable_bank #(
      .NUM_SRC (NUM_SRC),
      .REG_W   (REG_W),
      .NUM_REGS(NUM_REGS)
   ) u_en (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (en_wr),
      .wdata(en_wdata),
      .en   (en)
   );

   pvic_pending #(
      .NUM_SRC(NUM_SRC)
   ) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (src_evt),
      .clr  (clr),
      .pend (pend)
   );

   assign req = pend & en;

   pvic_prio_enc #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W),
      .LOW_WINS(LOW_WINS)
   ) u_enc (
      .req(req),
      .any(any_req),
      .idx(win_idx)
   );

   pvic_vec_gen #(
      .IDX_W     (IDX_W),
      .ADDR_W    (ADDR_W),
      .VEC_BASE  (VEC_BASE),
      .VEC_STRIDE(VEC_STRIDE)
   ) u_vec (
      .idx (win_idx),
      .addr(win_addr)
   );

   assign sense = any_req;
   assign irq   = any_req & gie_q;
   assign take  = insn_done & irq;

   always_comb begin
      clr = '0;
      if (take) clr[win_idx] = 1'b1;
   end

   // take and DI outrank EI / RETI
   always_comb begin
      if (take || di_stb)         gie_op = GIE_CLEAR;
      else if (ei_stb || reti_stb) gie_op = GIE_SET;
      else                         gie_op = GIE_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
      end else begin
         unique case (gie_op)
            GIE_CLEAR: gie_q <= 1'b0;
            GIE_SET:   gie_q <= 1'b1;
            default:   gie_q <= gie_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vv_q <= 1'b0;
         va_q <= '0;
      end else begin
         vv_q <= take;
         if (take) va_q <= win_addr;
      end
   end

   assign vec_valid = vv_q;
   assign vec_addr  = va_q;

   always_comb begin
      status                 = '0;
      status[STAT_SENSE_BIT] = sense;
      status[STAT_GIE_BIT]   = gie_q;
   end
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
   parameter int NUM_SRC    = 12,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 2,
   parameter int VEC_STRIDE = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_done,
   input logic              di_stb,
   input logic              ei_stb,
   input logic              reti_stb,
   input logic              irq,
   input logic              sense,
   input logic [7:0]        status,
   input logic              vec_valid,
   input logic [ADDR_W-1:0] vec_addr
);
   localparam int VEC_LAST = VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE;

   // R5
   take_pulses_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && irq) |=> vec_valid);

   // R5
   no_take_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(insn_done && irq) |=> !vec_valid);

   // R6
   take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && irq) |=> !status[2]);

   // R6
   vec_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (int'(vec_addr) >= VEC_BASE && int'(vec_addr) <= VEC_LAST
                     && ((int'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0));

   // R7
   di_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      di_stb |=> !status[2]);

   // R7
   ei_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ei_stb || reti_stb) && !di_stb && !(insn_done && irq)) |=> status[2]);

   // R9
   irq_needs_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sense && status[2]));

   // R8
   status_mirrors_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] == sense && status[6:3] == 4'b0 && status[1:0] == 2'b0);
endmodule

bind prio_vec_intc pvic_chk #(
   .NUM_SRC   (NUM_SRC),
   .ADDR_W    (ADDR_W),
   .VEC_BASE  (VEC_BASE),
   .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .insn_done(insn_done),
   .di_stb   (di_stb),
   .ei_stb   (ei_stb),
   .reti_stb (reti_stb),
   .irq      (irq),
   .sense    (sense),
   .status   (status),
   .vec_valid(vec_valid),
   .vec_addr (vec_addr)
);

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/100ps
module tb_prio_vec_intc;
   localparam int N  = 12;
   localparam int NR = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_evt = '0;
   logic [NR-1:0] en_wr = '0;
   logic [7:0]    en_wdata = '0;
   logic          di_stb = 1'b0, ei_stb = 1'b0, reti_stb = 1'b0, insn_done = 1'b0;
   logic          irq, vec_valid, sense;
   logic [15:0]   vec_addr;
   logic [7:0]    status;

   always #2.5 clk = ~clk;

   prio_vec_intc dut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .en_wr(en_wr), .en_wdata(en_wdata),
      .di_stb(di_stb), .ei_stb(ei_stb), .reti_stb(reti_stb), .insn_done(insn_done),
      .irq(irq), .vec_valid(vec_valid), .vec_addr(vec_addr), .sense(sense), .status(status)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // reference state
   logic [N-1:0] m_pend = '0, m_en = '0;
   logic         m_gie = 1'b0, m_vv = 1'b0;
   logic [15:0]  m_va = '0;

   function automatic int ref_win(input logic [N-1:0] r);
      for (int i = 0; i < N; i++) if (r[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] ref_status(input logic s, input logic g);
      return {s, 4'b0000, g, 2'b00};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic s;
      s = |(m_pend & m_en);
      chk("R8 sense", sense, s);
      chk("R9 irq", irq, s & m_gie);
      chk("R7 status", status, ref_status(s, m_gie));
      chk("R5 vec_valid", vec_valid, m_vv);
      if (m_vv) chk("R6 vec_addr", vec_addr, m_va);
   endtask

   // apply inputs (already set by caller), advance one edge, update model, compare
   task automatic step();
      logic [N-1:0] req, np, nen;
      logic take, ng;
      int w;
      req  = m_pend & m_en;
      w    = ref_win(req);
      take = insn_done && m_gie && (w >= 0);
      ng   = take ? 1'b0 : di_stb ? 1'b0 : (ei_stb || reti_stb) ? 1'b1 : m_gie;
      np   = m_pend;
      if (take) np[w] = 1'b0;
      np   = np | src_evt;
      nen  = m_en;
      for (int i = 0; i < N; i++) if (en_wr[i / 8]) nen[i] = en_wdata[i % 8];
      @(posedge clk);
      #1;
      m_pend = np; m_en = nen; m_gie = ng; m_vv = take;
      if (take) m_va = 16'(2 * (w + 1));
      src_evt = '0; en_wr = '0; en_wdata = '0;
      di_stb = 0; ei_stb = 0; reti_stb = 0; insn_done = 0;
      compare_all();
   endtask

   task automatic expect_vec(input string tag, input logic [15:0] exp);
      chk(tag, {vec_valid, vec_addr}, {1'b1, exp});
   endtask

   task automatic wr_en(input int r, input logic [7:0] d);
      en_wr[r] = 1'b1; en_wdata = d; step();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 sense", sense, 0);
      chk("R1 vec_valid", vec_valid, 0);
      chk("R1 status", status, 0);

      // R3: pending while disabled gives no sense
      src_evt[3] = 1; src_evt[9] = 1; step();
      chk("R3 disabled pending hidden", sense, 0);
      wr_en(1, 8'h02);                  // source 9 = reg 1 bit 1
      chk("R3 late enable shows latch", sense, 1);
      chk("R8 sense with global enable off", {sense, irq}, 2'b10);
      repeat (4) step();
      chk("R2 latch held", sense, 1);
      wr_en(0, 8'h08);                  // source 3 = reg 0 bit 3
      ei_stb = 1; step();
      // R5: no take without boundary
      repeat (3) step();
      chk("R5 no take without insn_done", vec_valid, 0);
      insn_done = 1; step();
      expect_vec("R4 lower source wins", 16'h0008);
      chk("R6 gie cleared", status[2], 0);
      chk("R9 irq dropped", irq, 0);
      insn_done = 1; step();
      chk("R6 no take while gie off", vec_valid, 0);
      // R11 nest via EI inside handler
      ei_stb = 1; step();
      insn_done = 1; step();
      expect_vec("R11 nested source 9", 16'h0014);
      chk("R2 all serviced", sense, 0);

      // R10 event same cycle as clear
      wr_en(0, 8'h01);
      src_evt[0] = 1; reti_stb = 1; step();
      insn_done = 1; src_evt[0] = 1; step();
      expect_vec("R10 first take", 16'h0002);
      chk("R10 latch kept", sense, 1);
      reti_stb = 1; step();
      insn_done = 1; step();
      expect_vec("R10 second take", 16'h0002);
      chk("R10 now clear", sense, 0);

      // R7 DI beats EI; take beats EI
      ei_stb = 1; step();
      di_stb = 1; ei_stb = 1; step();
      chk("R7 DI over EI", status[2], 0);
      // R6 last vector
      wr_en(1, 8'h0F);
      src_evt[11] = 1; ei_stb = 1; step();
      insn_done = 1; ei_stb = 1; step();
      expect_vec("R6 source 11 vector", 16'h0018);
      chk("R7 take over EI", status[2], 0);

      // random phase
      for (int c = 0; c < 3000; c++) begin
         for (int i = 0; i < N; i++) src_evt[i] = (($urandom % 16) == 0);
         if (($urandom % 20) == 0) begin
            en_wr[$urandom % NR] = 1'b1;
            en_wdata = 8'($urandom);
         end
         di_stb    = (($urandom % 12) == 0);
         ei_stb    = (($urandom % 5) == 0);
         reti_stb  = (($urandom % 9) == 0);
         insn_done = (($urandom % 2) == 0);
         step();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule